// File: doc/BRIEF.md
# Display Serial Write Receiver

This block is the receiving half of a write-only serial port for a display controller. It watches a serial clock, a serial data line, an active-low chip select and, in one of its two framings, a separate data/command pin. It turns each completed transfer into a single byte. It also produces a flag that routes that byte either to the command register or to display memory, and a write strobe that lasts one system clock.

Two framings are available, and a static mode input picks between them. In the 4-wire framing, eight data bits arrive most significant first. The data/command pin is sampled on the eighth rising edge. In the 3-wire framing, nine bits arrive: the data/command flag comes first, followed by the eight data bits, most significant first. The serial pins pass through a two-flop synchronizer. Rising serial-clock edges are then detected in the system clock domain, so the system clock must run at least four times faster than the serial clock. The serial data and data/command pins must be stable around each rising serial-clock edge.

Top module: `disp_wr_rx`

## Requirements
- R1: After synchronous reset the strobe is 0, the byte output is 0x00 and the flag output is 0.
- R2: With frame_3w = 0, a transfer is 8 rising serial-clock edges. The bit sampled on the first edge is bit 7 of the byte and the bit on the eighth edge is bit 0.
- R3: With frame_3w = 0, the flag equals the ser_dc level at the eighth rising edge. Its level at the earlier seven edges has no effect.
- R4: With frame_3w = 1, a transfer is 9 rising edges: first the flag, then byte bits 7 down to 0. The ser_dc pin has no effect.
- R5: A flag of 1 means the byte goes to display memory; a flag of 0 means it goes to the command register. The flag output wr_is_data carries this value unchanged.
- R6: Serial-clock edges while ser_cs_n is high (deasserted) shift nothing and produce no strobe.
- R7: Deasserting ser_cs_n in the middle of a transfer discards the partial bits. The next transfer starts at its first bit.
- R8: Transfers may follow one another without releasing ser_cs_n. Each completed transfer produces exactly one strobe.
- R9: wr_stb is high for exactly one system clock per transfer. wr_byte and wr_is_data change only together with a strobe.
- R10: A change of frame_3w takes effect only while ser_cs_n is high. A change made during a burst leaves that burst's framing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_3w | input | 1 | Framing select: 0 = 8-bit with pin flag, 1 = 9-bit with in-band flag |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_dc | input | 1 | Data/command pin, used only in 8-bit framing |
| ser_cs_n | input | 1 | Chip select, active low |
| wr_byte | output | 8 | Received byte |
| wr_is_data | output | 1 | 1 = display memory, 0 = command register |
| wr_stb | output | 1 | One-cycle write strobe |

## Verification
The bench sends every byte value in both framings as long bursts under one chip select, with the flag varied. A design with the bit order reversed, a miscounted frame length or a failed wrap would garble the bytes or lose them. In 8-bit framing, the data/command pin is held at the opposite value until the last bit, which exposes a flag sampled too early. In 9-bit framing the pin is held opposite the in-band flag throughout. Further cases cover:
- clock pulses sent while chip select is released, which a design without gating would shift in;
- a transfer cut off midway, which would otherwise shift every later byte;
- a mode change mid-burst, which a design without a latched mode would act on at once;
- the strobe width and the hold of the outputs, which catch a level-style strobe or outputs that drift between strobes.

// File: rtl/disp_wr_rx_pkg.sv
// Shared types for the display serial write receiver.
package disp_wr_rx_pkg;
    typedef enum logic {
        FRM_PIN_DC  = 1'b0,
        FRM_INBAND  = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/disp_wr_rx_sync.sv
// Multi-bit flop-chain synchronizer.
// Assumes: each bit is an independent slow-changing level; no bus coherency
// is implied beyond all bits seeing the same latency.
module disp_wr_rx_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Stage 0 captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= rst_val;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage resolves metastability of the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= rst_val;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/disp_wr_rx_edge.sv
// Rising-edge detector on a synchronized serial clock.
// Assumes: input is already in the clk domain and each level lasts
// at least two clk cycles.
module disp_wr_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;

    p_rise_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/disp_wr_rx_framer.sv
// Frame assembler: counts rising serial edges while selected, shifts data
// most significant first and reports a finished byte with its routing flag.
// Assumes: inputs are synchronized; 'rise' is one cycle wide.
module disp_wr_rx_framer
    import disp_wr_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              cs_idle,
    input  logic              rise,
    input  logic              dat,
    input  logic              dc,
    output logic              done,
    output logic [BYTE_W-1:0] byte_out,
    output logic              flag_out
);
    localparam int SH_W  = BYTE_W + 1;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_PIN = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_INB = CNT_W'(BYTE_W);

    frame_kind_e      mode_q;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic [SH_W-1:0]  sh_nxt;
    logic             at_last;

    // Next shift value and end-of-frame decode for the latched framing.
    always_comb begin
        sh_nxt  = {sh[SH_W-2:0], dat};
        at_last = (mode_q == FRM_INBAND) ? (cnt == LAST_INB) : (cnt == LAST_PIN);
    end

    // Bit counter, shifter and framing latch; select release restarts a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            mode_q <= FRM_PIN_DC;
        end else if (cs_idle) begin
            cnt    <= '0;
            mode_q <= frame_kind_e'(mode_in);
        end else if (rise) begin
            sh  <= sh_nxt;
            cnt <= at_last ? '0 : cnt + CNT_W'(1);
        end
    end

    // Finished byte and routing flag.
    always_comb begin
        done     = rise && !cs_idle && at_last;
        byte_out = sh_nxt[BYTE_W-1:0];
        flag_out = (mode_q == FRM_INBAND) ? sh_nxt[BYTE_W] : dc;
    end

    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_INB);
    p_cnt_pin_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == FRM_PIN_DC) |-> cnt <= LAST_PIN);
    p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> cnt == '0);
    p_idle_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |-> !done);
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_idle |=> $stable(mode_q));
endmodule

// File: rtl/disp_wr_rx_out.sv
// Output register: holds byte and flag between writes and issues a
// one-cycle strobe.
// Assumes: 'load' is never high in two consecutive cycles.
module disp_wr_rx_out #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              flag_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic              flag_q,
    output logic              stb_q
);
    // Capture a finished byte and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            flag_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= load;
            if (load) begin
                byte_q <= byte_in;
                flag_q <= flag_in;
            end
        end
    end

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_q |-> ($stable(byte_q) && $stable(flag_q)));
endmodule

// File: rtl/disp_wr_rx.sv
// Display serial write receiver top.
// Synchronizes the serial pins and finds rising serial-clock edges, then
// assembles 8-bit (pin flag) or 9-bit (in-band flag) transfers and emits
// byte + flag + one-cycle strobe.
// Assumes: clk is at least 4x the serial clock; frame_3w is quasi-static.
module disp_wr_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_3w,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_dc,
    input  logic              ser_cs_n,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_is_data,
    output logic              wr_stb
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] pins_raw;
    logic [NPIN-1:0] pins_sync;
    logic            sclk_s, sdat_s, sdc_s, scs_n_s;
    logic            rise;
    logic            done;
    logic [BYTE_W-1:0] f_byte;
    logic            f_flag;

    assign pins_raw = {ser_cs_n, ser_dc, ser_dat, ser_clk};
    assign {scs_n_s, sdc_s, sdat_s, sclk_s} = pins_sync;

    disp_wr_rx_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (4'b1000),
        .d       (pins_raw),
        .q       (pins_sync)
    );

    disp_wr_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .rise  (rise)
    );

    disp_wr_rx_framer #(.BYTE_W(BYTE_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_in  (frame_3w),
        .cs_idle  (scs_n_s),
        .rise     (rise),
        .dat      (sdat_s),
        .dc       (sdc_s),
        .done     (done),
        .byte_out (f_byte),
        .flag_out (f_flag)
    );

    disp_wr_rx_out #(.BYTE_W(BYTE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (done),
        .byte_in (f_byte),
        .flag_in (f_flag),
        .byte_q  (wr_byte),
        .flag_q  (wr_is_data),
        .stb_q   (wr_stb)
    );

    p_done_needs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rise);
endmodule

// File: tb/disp_wr_rx_test.sv
module disp_wr_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_3w = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_dc = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic [7:0] wr_byte;
    logic       wr_is_data;
    logic       wr_stb;

    int n_chk = 0;
    int n_bad = 0;
    int n_stb = 0;
    int n_wide = 0;
    logic       prev_stb = 1'b0;
    logic [7:0] log_b [0:1023];
    logic       log_f [0:1023];

    always #4 clk = ~clk;   // 125 MHz

    disp_wr_rx uut (
        .clk(clk), .rst_n(rst_n), .frame_3w(frame_3w),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_dc(ser_dc), .ser_cs_n(ser_cs_n),
        .wr_byte(wr_byte), .wr_is_data(wr_is_data), .wr_stb(wr_stb)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (wr_stb) begin
            if (n_stb < 1024) begin
                log_b[n_stb] = wr_byte;
                log_f[n_stb] = wr_is_data;
            end
            n_stb = n_stb + 1;
            if (prev_stb) n_wide = n_wide + 1;
        end
        prev_stb = wr_stb;
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        ser_clk = 1'b0; ser_dat = b; #40;
        ser_clk = 1'b1; #40;
    endtask

    task automatic cs_on();
        ser_cs_n = 1'b0; #80;
    endtask

    task automatic cs_off();
        #40; ser_cs_n = 1'b1; #200;
    endtask

    // 8-bit framing; dc pin opposite until the last bit (R3).
    task automatic frame_pin(input logic [7:0] v, input logic f);
        for (int i = 7; i >= 0; i--) begin
            ser_dc = (i == 0) ? f : ~f;
            sbit(v[i]);
        end
    endtask

    // 9-bit framing; dc pin held opposite to the in-band flag (R4).
    task automatic frame_inb(input logic [7:0] v, input logic f);
        ser_dc = ~f;
        sbit(f);
        for (int i = 7; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic expect_at(input int idx, input logic [7:0] v, input logic f, input string req);
        chk(req, log_b[idx] == v, log_b[idx], v);
        chk(req, log_f[idx] == f, log_f[idx], f);
    endtask

    initial begin
        int base;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 stb", wr_stb == 1'b0, wr_stb, 0);
        chk("R1 byte", wr_byte == 8'h00, wr_byte, 0);
        chk("R1 flag", wr_is_data == 1'b0, wr_is_data, 0);

        // R2 R3 R5 R8: all bytes in 8-bit framing, one burst
        frame_3w = 1'b0; #200;
        base = n_stb;
        cs_on();
        for (int v = 0; v < 256; v++) frame_pin(8'(v), v[0] ^ v[7]);
        cs_off();
        chk("R8 count pin", n_stb - base == 256, n_stb - base, 256);
        for (int v = 0; v < 256; v++) expect_at(base + v, 8'(v), v[0] ^ v[7], "R2/R3/R5 pin");

        // R4 R5 R8: all bytes in 9-bit framing
        frame_3w = 1'b1; #200;
        base = n_stb;
        cs_on();
        for (int v = 0; v < 256; v++) frame_inb(8'(v), v[1] ^ v[6]);
        cs_off();
        chk("R8 count inb", n_stb - base == 256, n_stb - base, 256);
        for (int v = 0; v < 256; v++) expect_at(base + v, 8'(v), v[1] ^ v[6], "R4/R5 inb");

        // R6: clocks with select released are ignored
        frame_3w = 1'b0; #200;
        base = n_stb;
        for (int i = 0; i < 20; i++) sbit(i[0]);
        chk("R6 no strobe", n_stb == base, n_stb - base, 0);
        cs_on();
        frame_pin(8'h3C, 1'b1);
        cs_off();
        chk("R6 count", n_stb - base == 1, n_stb - base, 1);
        expect_at(base, 8'h3C, 1'b1, "R6 clean frame");

        // R7: partial frame discarded (both framings)
        base = n_stb;
        cs_on();
        for (int i = 0; i < 5; i++) sbit(1'b1);
        cs_off();
        cs_on();
        frame_pin(8'hA5, 1'b0);
        cs_off();
        chk("R7 count pin", n_stb - base == 1, n_stb - base, 1);
        expect_at(base, 8'hA5, 1'b0, "R7 restart pin");
        frame_3w = 1'b1; #200;
        base = n_stb;
        cs_on();
        for (int i = 0; i < 7; i++) sbit(1'b1);
        cs_off();
        cs_on();
        frame_inb(8'h5A, 1'b1);
        cs_off();
        chk("R7 count inb", n_stb - base == 1, n_stb - base, 1);
        expect_at(base, 8'h5A, 1'b1, "R7 restart inb");

        // R10: mode change mid-burst does not apply until release
        frame_3w = 1'b0; #200;
        base = n_stb;
        cs_on();
        frame_3w = 1'b1;
        frame_pin(8'hC3, 1'b1);
        frame_pin(8'h18, 1'b0);
        cs_off();
        chk("R10 count", n_stb - base == 2, n_stb - base, 2);
        expect_at(base,     8'hC3, 1'b1, "R10 old framing");
        expect_at(base + 1, 8'h18, 1'b0, "R10 old framing");
        base = n_stb;
        cs_on();
        frame_inb(8'h81, 1'b1);
        cs_off();
        chk("R10 new count", n_stb - base == 1, n_stb - base, 1);
        expect_at(base, 8'h81, 1'b1, "R10 new framing");

        // R9: one-cycle strobe, outputs held after last write
        repeat (10) @(negedge clk);
        chk("R9 wide strobes", n_wide == 0, n_wide, 0);
        chk("R9 hold byte", wr_byte == 8'h81, wr_byte, 8'h81);
        chk("R9 hold flag", wr_is_data == 1'b1, wr_is_data, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule